// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is an SPI master run from a simple register bus. Software picks a serial clock rate, loads how many bytes a whole exchange lasts and how many of those bytes come from the transmit queue, fills the transmit queue, and then sets the exchange-start bit. The controller pulls chip select low and clocks the whole burst in SPI mode 0, most significant bit first. When the transmit count is used up, the rest of the burst is clocked out as 0x00 filler bytes. Every byte seen on the data-in line goes into the receive queue, including the bytes clocked while command and address bytes go out. Software therefore skips the leading bytes it does not need.

A typical flash read loads a transmit count of 4, with an opcode and three address bytes, and a burst count of 4 plus the payload length. Software then polls the start bit or the status register and drains the receive queue.

The register bus accepts a request in every cycle and has no back-pressure. A read request is answered exactly one cycle later by `bus_rvalid` and `bus_rdata`, and that response cannot be stalled. The SPI pins are plain outputs and a plain input.

Top module: `spi_burst_master`

## Requirements
- R1: The control register is at offset 0x08. Bit 0 is enable and bit 1 is master mode; both are stored and read back. A write that sets bits 0, 1 and 10 with bits 8 and 9 clear starts a burst, provided the controller is idle and the burst count is nonzero. Bit 10 reads 1 while a burst runs and 0 otherwise. A start write that lacks bit 0 or bit 1 starts nothing.
- R2: The register offsets are: receive data 0x00, transmit data 0x04, control 0x08, clock control 0x1C, burst count 0x20, transmit count 0x24 and status 0x28. A read request returns its data with `bus_rvalid` high in the following cycle, and only then.
- R3: The clock-control register resets to 0x1001. Each SCLK half-period lasts (bits [7:0] + 1) module clocks, so 0x1000 divides the module clock by 2 and 0x1001 divides it by 4.
- R4: Chip select is low for exactly burst_count × 16 × half-period module clocks. SCLK idles low, and its first rising edge comes one half-period after chip select falls. Data-out changes only on falling SCLK edges, or when chip select falls.
- R5: Bytes go out most significant bit first. The first transmit-count bytes are popped from the transmit queue in write order. Every later byte is 0x00. If the queue is empty when a byte is due, 0x00 is sent and nothing is popped.
- R6: The data-in line is sampled on every rising SCLK edge. Each of the burst-count received bytes, command phase included, is pushed into the receive queue, first bit as the MSB.
- R7: Each queue holds 64 bytes, and a push into a full queue is dropped. The status register reports the receive fill level in bits [6:0] and the transmit fill level in bits [22:16].
- R8: A write to the transmit data offset pushes bits [7:0]. A read of the receive data offset pops one byte and returns it; reading an empty queue returns 0.
- R9: Control bit 8 empties the transmit queue and bit 9 empties the receive queue. Both bits clear themselves and always read as 0.
- R10: While a burst runs, writes to clock control, burst count and transmit count are ignored, and so is a further start write.
- R11: A start write with a burst count of 0 leaves chip select high, and bit 10 reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read request) |
| bus_rdata | output | 32 | Read data |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The pin-timing assertions assume that chip select and the serial clock come only from the engine's own divider ticks. They also assume that a read response can never be requested outside a bus read, so no input sequence can break them except a reset in the middle of a burst. The queue-level assertions need nothing from the inputs. The stimulus never writes the transmit queue or reads status while a burst runs, never combines a queue reset with a start, and keeps every burst short enough that the reference model's whole-burst prediction of the receive queue stays valid.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned CLK_W  = 13;

  localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TXD   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CLK   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_BURST = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h28;

  localparam int CB_EN     = 0;
  localparam int CB_MASTER = 1;
  localparam int CB_TXRST  = 8;
  localparam int CB_RXRST  = 9;
  localparam int CB_XCH    = 10;

  localparam logic [CLK_W-1:0] CLK_RESET = 13'h1001;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run & (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] burst_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [7:0]       tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n
);
  localparam int IW = CNT_W + 1;

  logic [IW-1:0] byte_idx, fetch_idx;
  logic [2:0]    bit_idx;
  logic [7:0]    tx_sh, rx_sh, next_byte;
  logic          launch, fall, byte_end, last_byte, take, fetch;

  assign launch    = start & ~busy & (burst_cnt != '0);
  assign fall      = busy & tick & sclk;
  assign byte_end  = fall & (bit_idx == 3'd7);
  assign last_byte = (byte_idx + 1'b1) == {1'b0, burst_cnt};
  assign fetch_idx = launch ? '0 : byte_idx + 1'b1;
  assign take      = (fetch_idx < {1'b0, tx_cnt}) & ~tx_empty;
  assign next_byte = take ? tx_data : 8'h00;
  assign fetch     = launch | (byte_end & ~last_byte);
  assign tx_pop    = fetch & take;
  assign rx_push   = byte_end;
  assign rx_byte   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (launch) begin
      busy     <= 1'b1;
      cs_n     <= 1'b0;
      sclk     <= 1'b0;
      tx_sh    <= next_byte;
      mosi     <= next_byte[7];
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (busy && tick) begin
      if (!sclk) begin
        sclk  <= 1'b1;
        rx_sh <= {rx_sh[6:0], miso};
      end else begin
        sclk <= 1'b0;
        if (bit_idx == 3'd7) begin
          if (last_byte) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            mosi <= 1'b0;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            tx_sh    <= next_byte;
            mosi     <= next_byte[7];
            bit_idx  <= '0;
          end
        end else begin
          bit_idx <= bit_idx + 1'b1;
          tx_sh   <= {tx_sh[6:0], 1'b0};
          mosi    <= tx_sh[6];
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_bm_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic             ctl_en, ctl_master;
  logic [CLK_W-1:0] clk_ctl;
  logic [CNT_W-1:0] burst_cnt, tx_cnt;
  logic             wr, rd, ctl_wr, busy, tick;
  logic             start, tx_clr, rx_clr;
  logic             tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [31:0]      rd_mux;
  logic             unused_ok;

  assign wr      = bus_req & bus_we;
  assign rd      = bus_req & ~bus_we;
  assign ctl_wr  = wr & (bus_addr == OFS_CTL);
  assign tx_clr  = ctl_wr & bus_wdata[CB_TXRST];
  assign rx_clr  = ctl_wr & bus_wdata[CB_RXRST];
  assign start   = ctl_wr & bus_wdata[CB_XCH] & bus_wdata[CB_EN] & bus_wdata[CB_MASTER]
                 & ~bus_wdata[CB_TXRST] & ~bus_wdata[CB_RXRST];
  assign tx_push = wr & (bus_addr == OFS_TXD);
  assign rx_pop  = rd & (bus_addr == OFS_RXD);
  assign unused_ok = ^{bus_wdata[31:16], tx_full, rx_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en     <= 1'b0;
      ctl_master <= 1'b0;
      clk_ctl    <= CLK_RESET;
      burst_cnt  <= '0;
      tx_cnt     <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_CTL: begin
          ctl_en     <= bus_wdata[CB_EN];
          ctl_master <= bus_wdata[CB_MASTER];
        end
        OFS_CLK:   if (!busy) clk_ctl   <= bus_wdata[CLK_W-1:0];
        OFS_BURST: if (!busy) burst_cnt <= bus_wdata[CNT_W-1:0];
        OFS_TXCNT: if (!busy) tx_cnt    <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_RXD:   rd_mux = 32'(rx_head);
      OFS_CTL:   rd_mux = 32'({busy, 8'b0, ctl_master, ctl_en});
      OFS_CLK:   rd_mux = 32'(clk_ctl);
      OFS_BURST: rd_mux = 32'(burst_cnt);
      OFS_TXCNT: rd_mux = 32'(tx_cnt);
      OFS_STAT:  rd_mux = {16'(tx_level), 16'(rx_level)};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .half_m1(clk_ctl[DIV_W-1:0]), .tick(tick)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .burst_cnt(burst_cnt), .tx_cnt(tx_cnt),
    .tx_data(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .miso(spi_miso), .busy(busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input logic             bus_req,
  input logic             bus_we,
  input logic             bus_rvalid,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level
);
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> $fell(spi_sclk));

  a_r7_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(FIFO_DEPTH));

  a_r7_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(FIFO_DEPTH));

  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));
endmodule

bind spi_burst_master spi_burst_master_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .bus_req(bus_req), .bus_we(bus_we),
  .bus_rvalid(bus_rvalid), .rx_level(rx_level), .tx_level(tx_level)
);

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int vec = 0, bad = 0;
  bit run_cmp = 1'b0;

  always #5 clk = ~clk;

  spi_burst_master dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // ---------------- reference model ----------------
  bit          m_busy, m_en, m_ms, exp_rv;
  int          m_t, m_bc, m_tc;
  logic [12:0] m_cctl;
  logic [31:0] exp_rd;
  int          txq[$], rxq[$], txb[$];

  function automatic logic [7:0] slv(int b);
    return 8'((b * 53 + 165) & 255);
  endfunction

  function automatic int half(logic [12:0] c);
    return int'(c[7:0]) + 1;
  endfunction

  function automatic logic slave_bit(int t, int h);
    int b, k;
    logic [7:0] v;
    b = t / (16 * h);
    k = (t % (16 * h)) / (2 * h);
    v = slv(b);
    return v[7 - k];
  endfunction

  assign spi_miso = m_busy ? slave_bit(m_t, half(m_cctl)) : 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_en <= 0; m_ms <= 0; m_t <= 0; m_bc <= 0; m_tc <= 0;
      m_cctl <= 13'h1001; exp_rv <= 0; exp_rd <= '0;
      txq.delete(); rxq.delete(); txb.delete();
    end else begin
      exp_rv <= 1'b0;
      if (m_busy) begin
        if (m_t + 1 == m_bc * 16 * half(m_cctl)) begin
          m_busy <= 1'b0;
          for (int i = 0; i < m_bc; i++) if (rxq.size() < 64) rxq.push_back(int'(slv(i)));
        end else m_t <= m_t + 1;
      end
      if (bus_req && bus_we) begin
        case (bus_addr)
          6'h04: if (txq.size() < 64) txq.push_back(int'(bus_wdata[7:0]));
          6'h08: begin
            m_en <= bus_wdata[0];
            m_ms <= bus_wdata[1];
            if (bus_wdata[8]) txq.delete();
            if (bus_wdata[9]) rxq.delete();
            if (bus_wdata[10] && bus_wdata[0] && bus_wdata[1] && !bus_wdata[8] &&
                !bus_wdata[9] && !m_busy && m_bc != 0) begin
              m_busy <= 1'b1;
              m_t <= 0;
              txb.delete();
              for (int i = 0; i < m_bc; i++)
                if (i < m_tc && txq.size() > 0) txb.push_back(txq.pop_front());
                else txb.push_back(0);
            end
          end
          6'h1C: if (!m_busy) m_cctl <= bus_wdata[12:0];
          6'h20: if (!m_busy) m_bc <= int'(bus_wdata[15:0]);
          6'h24: if (!m_busy) m_tc <= int'(bus_wdata[15:0]);
          default: ;
        endcase
      end else if (bus_req) begin
        logic [31:0] v;
        v = '0;
        case (bus_addr)
          6'h00: v = (rxq.size() > 0) ? 32'(rxq.pop_front()) : 32'd0;
          6'h08: v = (32'(m_busy) << 10) | (32'(m_ms) << 1) | 32'(m_en);
          6'h1C: v = 32'(m_cctl);
          6'h20: v = 32'(m_bc);
          6'h24: v = 32'(m_tc);
          6'h28: v = (32'(txq.size()) << 16) | 32'(rxq.size());
          default: v = '0;
        endcase
        exp_rv <= 1'b1;
        exp_rd <= v;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      logic ecs, esc, emo;
      if (!m_busy) begin
        ecs = 1; esc = 0; emo = 0;
      end else begin
        int h, per, b, r, bi, byt;
        h = half(m_cctl); per = 16 * h;
        b = m_t / per; r = m_t % per; bi = r / (2 * h);
        byt = txb[b];
        ecs = 0; esc = (r % (2 * h)) >= h; emo = byt[7 - bi];
      end
      vec++;
      if (spi_cs_n !== ecs) begin bad++; $display("FAIL R4 cs_n actual=%b expected=%b t=%0t", spi_cs_n, ecs, $time); end
      if (spi_sclk !== esc) begin bad++; $display("FAIL R3 sclk actual=%b expected=%b t=%0t", spi_sclk, esc, $time); end
      if (spi_mosi !== emo) begin bad++; $display("FAIL R5 mosi actual=%b expected=%b t=%0t", spi_mosi, emo, $time); end
      if (bus_rvalid !== exp_rv) begin bad++; $display("FAIL R2 rvalid actual=%b expected=%b", bus_rvalid, exp_rv); end
      else if (exp_rv && bus_rdata !== exp_rd) begin
        bad++; $display("FAIL R2 rdata actual=%h expected=%h t=%0t", bus_rdata, exp_rd, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic brd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    while (!spi_cs_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);

    // reset state
    chk("R4 reset cs_n", 32'(spi_cs_n), 32'd1);
    brd(6'h08, d); chk("R1 reset ctl", d, 32'h0);
    brd(6'h1C, d); chk("R3 reset clock ctl", d, 32'h1001);
    brd(6'h28, d); chk("R7 reset status", d, 32'h0);

    // zero burst count: nothing starts
    bwr(6'h08, 32'h403);
    chk("R11 cs_n stays high", 32'(spi_cs_n), 32'd1);
    brd(6'h08, d); chk("R11 start bit clear", d, 32'h3);

    // command + address then dummy bytes, divide by 4
    bwr(6'h24, 4); bwr(6'h20, 12);
    bwr(6'h04, 8'h03); bwr(6'h04, 8'h12); bwr(6'h04, 8'h34); bwr(6'h04, 8'h56);
    bwr(6'h08, 32'h403);
    brd(6'h08, d); chk("R1 start bit set while running", d, 32'h403);
    wait_idle();
    brd(6'h08, d); chk("R1 start bit self clears", d, 32'h3);
    brd(6'h28, d); chk("R6 all burst bytes captured", d, 32'd12);
    for (int i = 0; i < 12; i++) begin
      brd(6'h00, d); chk("R6 received byte", d, 32'(slv(i)));
    end

    // divide by 2, cs low duration, one trailing dummy
    bwr(6'h1C, 32'h1000); bwr(6'h24, 2); bwr(6'h20, 3);
    bwr(6'h04, 8'hAA); bwr(6'h04, 8'h55);
    bwr(6'h08, 32'h403);
    n = 0;
    while (!spi_cs_n) begin n++; @(negedge clk); end
    chk("R3 R4 cs low cycles at div 2", 32'(n), 32'd48);
    for (int i = 0; i < 3; i++) begin
      brd(6'h00, d); chk("R6 byte at div 2", d, 32'(slv(i)));
    end
    brd(6'h00, d); chk("R8 pop empty returns 0", d, 32'h0);

    // transmit count larger than burst: leftovers stay queued
    bwr(6'h24, 4); bwr(6'h20, 2);
    for (int i = 0; i < 4; i++) bwr(6'h04, 32'(8'hC0 + i));
    bwr(6'h08, 32'h403);
    wait_idle();
    brd(6'h28, d); chk("R5 leftover tx bytes", d, 32'h0002_0002);
    bwr(6'h08, 32'h103);
    brd(6'h28, d); chk("R9 tx reset empties tx only", d, 32'h0000_0002);
    bwr(6'h08, 32'h203);
    brd(6'h28, d); chk("R9 rx reset empties rx", d, 32'h0);
    brd(6'h08, d); chk("R9 reset bits read 0", d, 32'h3);

    // transmit overflow
    for (int i = 0; i < 70; i++) bwr(6'h04, 32'(i));
    brd(6'h28, d); chk("R7 tx full at 64", d, 32'h0040_0000);
    bwr(6'h08, 32'h103);

    // receive overflow, all dummy bytes
    bwr(6'h24, 0); bwr(6'h20, 70);
    bwr(6'h08, 32'h403);
    wait_idle();
    brd(6'h28, d); chk("R7 rx full at 64", d, 32'd64);
    brd(6'h00, d); chk("R6 first byte kept on overflow", d, 32'(slv(0)));
    bwr(6'h08, 32'h203);

    // writes during a burst are ignored
    bwr(6'h1C, 32'h1001); bwr(6'h20, 2);
    bwr(6'h08, 32'h403);
    bwr(6'h20, 9); bwr(6'h1C, 32'h1000); bwr(6'h08, 32'h403);
    wait_idle();
    chk("R10 no second burst", 32'(spi_cs_n), 32'd1);
    brd(6'h20, d); chk("R10 burst count kept", d, 32'd2);
    brd(6'h1C, d); chk("R10 clock ctl kept", d, 32'h1001);
    brd(6'h28, d); chk("R10 only one burst received", d, 32'd2);
    bwr(6'h08, 32'h203);

    // start without enable
    bwr(6'h08, 32'h400);
    chk("R1 no start without enable", 32'(spi_cs_n), 32'd1);
    brd(6'h08, d); chk("R1 ctl after disabled start", d, 32'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule